// File: doc/BRIEF.md
# Shared-Mode Bus Access Arbiter for a Block-Transfer Engine

This block decides, in shared (non-hogging) mode, when a block-transfer engine may hold the system bus and when the bus goes back to the CPU. Both phases are measured in memory accesses, not in clock ticks. The engine's turn covers 65 accesses: one to take the bus, 63 data accesses, and one to give it back. The CPU's turn lasts until the CPU has made 64 real memory accesses, each marked by one assertion of the address strobe. A CPU instruction that runs long with few bus accesses, such as a divide, therefore stretches the CPU's turn in time and holds the engine off.

A single access counter serves both phases. In the engine's turn it counts the engine's per-access done pulses, which stand for its outgoing strobe. In the CPU's turn it counts falling edges of the incoming address strobe. The strobe is sampled synchronously under the system clock enable and is never used as a clock. If the transfer ends partway through a turn, the block drops the bus at once, clears the counter and goes idle.

Top module: `bus_share_arbiter`

## Requirements
- R1: After reset `bus_req` and `eng_run` are 0, and they stay 0 while `xfer_req` is 0.
- R2: From idle, `xfer_req` sampled at 1 on an enabled edge raises `bus_req` after that edge. `eng_run` rises only after the first enabled edge that samples `bus_grant` at 1, and stays 0 before that.
- R3: The engine's turn counts the bus take-over as access 1. Each `eng_access` pulse sampled on an enabled edge while `eng_run` is 1 adds one. The 63rd data pulse, together with the release, brings the count to 65. `eng_run` and `bus_req` both fall after the edge that samples that 63rd pulse, whatever the gaps between pulses.
- R4: After a normal release, and once `bus_grant` is sampled at 0, the CPU's turn counts strobe assertions. An assertion is `as_n` (active low) sampled at 0 on an enabled edge when the previous enabled sample was 1. `bus_req` rises after the edge that samples the 64th assertion and not earlier, for any gap length between strobes, including gaps of tens of enabled cycles.
- R5: The shared counter is set to 1 when the engine takes the bus and cleared on entry to each CPU turn and on every return to idle. It never exceeds 65, so every engine turn after a restart again allows exactly 63 data accesses.
- R6: While `clk_en` is 0 the block does not change state. Strobe pulses and `eng_access` pulses that begin and end while `clk_en` is 0 are not counted.
- R7: `xfer_done` sampled during the engine's turn drops `eng_run` and `bus_req` after that edge. Once `bus_grant` is sampled at 0 the block is idle: `bus_req` stays 0 through any number of strobes until `xfer_req` is seen again.
- R8: `xfer_done` sampled during the CPU's turn, or while the bus is being requested, returns the block to idle with `bus_req` at 0.
- R9: `eng_access` pulses outside the engine's turn have no effect. The CPU's turn still ends on exactly the 64th strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | System clock enable; all sampling and state changes happen only on enabled edges |
| xfer_req | input | 1 | The engine has a transfer to run |
| xfer_done | input | 1 | The transfer has finished |
| eng_access | input | 1 | One-enable-cycle pulse per completed engine data access |
| as_n | input | 1 | System address strobe, active low |
| bus_grant | input | 1 | The CPU side has granted the bus |
| bus_req | output | 1 | Bus request to the CPU side |
| eng_run | output | 1 | The engine owns the bus and may perform data accesses |

## Verification
The hardest case to reach from the ports is a CPU turn whose strobe count is correct but whose timing is unusual. This covers gaps of tens of enabled cycles between strobes, as a divide would cause, and strobe or engine pulses that fit wholly inside periods with the clock enable low. The bench models a CPU with gap lengths taken from a pseudo-random sequence and a separate long-gap mode. It inserts clock-enable-low pulses and stray engine pulses into the gaps, and checks that the request still rises on exactly the 64th counted strobe. Early finishes are driven both inside the engine's turn and inside the CPU's turn, and each is followed by a full turn that shows the counter started again from zero.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_OWN  = 3'd2,
    ST_REL  = 3'd3,
    ST_CPU  = 3'd4
  } arb_state_t;

  typedef enum logic [2:0] {
    CNT_HOLD  = 3'd0,
    CNT_CLEAR = 3'd1,
    CNT_ACQ   = 3'd2,
    CNT_STEP  = 3'd3,
    CNT_CLOSE = 3'd4
  } cnt_op_t;

  // Counter width able to hold the larger of the two windows.
  function automatic int unsigned cnt_bits(input int unsigned eng_w,
                                           input int unsigned cpu_w);
    int unsigned m;
    m = (eng_w > cpu_w) ? eng_w : cpu_w;
    return $clog2(m + 1);
  endfunction

  // The access being counted now, plus the release that follows it,
  // fills the engine window.
  function automatic bit eng_last(input int unsigned cnt,
                                  input int unsigned eng_w);
    return (cnt + 2) == eng_w;
  endfunction

  // The strobe being counted now fills the CPU window.
  function automatic bit cpu_last(input int unsigned cnt,
                                  input int unsigned cpu_w);
    return (cnt + 1) == cpu_w;
  endfunction

endpackage

// File: rtl/arb_strobe_edge.sv
module arb_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic as_n,
  output logic as_fall
);
  logic as_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      as_prev <= 1'b1;
    else if (clk_en) as_prev <= as_n;
  end

  assign as_fall = clk_en & as_prev & ~as_n;
endmodule

// File: rtl/arb_access_counter.sv
module arb_access_counter #(
  parameter int unsigned CW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  arb_pkg::cnt_op_t op,
  output logic [CW-1:0]   cnt
);
  import arb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else begin
      unique case (op)
        CNT_CLEAR: cnt <= '0;
        CNT_ACQ:   cnt <= CW'(1);
        CNT_STEP:  cnt <= cnt + CW'(1);
        CNT_CLOSE: cnt <= cnt + CW'(2);
        default:   cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/arb_window_fsm.sv
module arb_window_fsm #(
  parameter int unsigned ENG_WINDOW = 65,
  parameter int unsigned CPU_WINDOW = 64,
  parameter int unsigned CW         = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en,
  input  logic                xfer_req,
  input  logic                xfer_done,
  input  logic                bus_grant,
  input  logic                eng_access,
  input  logic                as_fall,
  input  logic [CW-1:0]       cnt,
  output arb_pkg::arb_state_t st,
  output arb_pkg::cnt_op_t    op
);
  import arb_pkg::*;

  arb_state_t st_d;
  logic       fin_q, fin_d;
  logic       hit_eng, hit_cpu;

  assign hit_eng = eng_last(32'(cnt), ENG_WINDOW);
  assign hit_cpu = cpu_last(32'(cnt), CPU_WINDOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      fin_q <= 1'b0;
    end else begin
      st    <= st_d;
      fin_q <= fin_d;
    end
  end

  always_comb begin
    st_d  = st;
    fin_d = fin_q;
    op    = CNT_HOLD;
    if (clk_en) begin
      unique case (st)
        ST_IDLE: if (xfer_req) st_d = ST_REQ;
        ST_REQ: begin
          if (xfer_done) begin
            st_d = ST_IDLE;
            op   = CNT_CLEAR;
          end else if (bus_grant) begin
            st_d = ST_OWN;
            op   = CNT_ACQ;
          end
        end
        ST_OWN: begin
          if (xfer_done) begin
            st_d  = ST_REL;
            fin_d = 1'b1;
            op    = CNT_CLEAR;
          end else if (eng_access) begin
            if (hit_eng) begin
              st_d = ST_REL;
              op   = CNT_CLOSE;
            end else begin
              op = CNT_STEP;
            end
          end
        end
        ST_REL: begin
          if (!bus_grant) begin
            st_d  = fin_q ? ST_IDLE : ST_CPU;
            fin_d = 1'b0;
            op    = CNT_CLEAR;
          end
        end
        ST_CPU: begin
          if (xfer_done) begin
            st_d = ST_IDLE;
            op   = CNT_CLEAR;
          end else if (as_fall) begin
            if (hit_cpu) begin
              st_d = ST_REQ;
              op   = CNT_CLEAR;
            end else begin
              op = CNT_STEP;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter #(
  parameter int unsigned ENG_WINDOW = 65,
  parameter int unsigned CPU_WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic xfer_req,
  input  logic xfer_done,
  input  logic eng_access,
  input  logic as_n,
  input  logic bus_grant,
  output logic bus_req,
  output logic eng_run
);
  import arb_pkg::*;

  localparam int unsigned CW = cnt_bits(ENG_WINDOW, CPU_WINDOW);

  // Named internal events, also observed by the bound checker.
  logic          as_fall;
  logic [CW-1:0] cnt_q;
  arb_state_t    st_q;
  cnt_op_t       cnt_op;

  arb_strobe_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .as_n    (as_n),
    .as_fall (as_fall)
  );

  arb_access_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (cnt_op),
    .cnt   (cnt_q)
  );

  arb_window_fsm #(
    .ENG_WINDOW (ENG_WINDOW),
    .CPU_WINDOW (CPU_WINDOW),
    .CW         (CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .xfer_req   (xfer_req),
    .xfer_done  (xfer_done),
    .bus_grant  (bus_grant),
    .eng_access (eng_access),
    .as_fall    (as_fall),
    .cnt        (cnt_q),
    .st         (st_q),
    .op         (cnt_op)
  );

  assign bus_req = (st_q == ST_REQ) || (st_q == ST_OWN);
  assign eng_run = (st_q == ST_OWN);
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned ENG_WINDOW = 65,
  parameter int unsigned CPU_WINDOW = 64,
  parameter int unsigned CW         = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clk_en,
  input logic                xfer_done,
  input logic                bus_grant,
  input logic                bus_req,
  input logic                eng_run,
  input arb_pkg::arb_state_t st,
  input logic [CW-1:0]       cnt,
  input logic                as_fall
);
  import arb_pkg::*;

  localparam logic [CW-1:0] ENG_FULL = CW'(ENG_WINDOW);
  localparam logic [CW-1:0] CPU_LAST = CW'(CPU_WINDOW - 1);

  // R2: the engine starts only after an enabled edge that saw the grant
  p_own_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_run) |-> ($past(bus_grant) && $past(clk_en)));

  // R3: the engine turn closes either full or cleared by an early finish
  p_window_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_run) |-> (cnt == ENG_FULL || cnt == '0));

  // R4: the request comes back only on the last strobe of the CPU turn
  p_cpu_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && $past(st == ST_CPU)) |-> ($past(cnt) == CPU_LAST && $past(as_fall)));

  // R4: in the CPU turn the count moves only on a strobe assertion
  p_cpu_counts_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CPU && clk_en && !as_fall && !xfer_done) |=> $stable(cnt));

  // R5: the shared counter never passes the engine window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ENG_FULL);

  // R6: nothing moves on an edge with the clock enable low
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(st) && $stable(cnt)));

  // R8: a finish during the CPU turn or the request returns to idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && xfer_done && (st == ST_CPU || st == ST_REQ)) |=> (st == ST_IDLE && !bus_req));
endmodule

bind bus_share_arbiter arb_checker #(
  .ENG_WINDOW (ENG_WINDOW),
  .CPU_WINDOW (CPU_WINDOW),
  .CW         (CW)
) u_arb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .xfer_done (xfer_done),
  .bus_grant (bus_grant),
  .bus_req   (bus_req),
  .eng_run   (eng_run),
  .st        (st_q),
  .cnt       (cnt_q),
  .as_fall   (as_fall)
);

// File: tb/bus_share_arbiter_bench.sv
module bus_share_arbiter_bench;
  localparam int CLK_P     = 10;
  localparam int ENG_W     = 65;
  localparam int CPU_W     = 64;
  localparam int DATA_EXP  = ENG_W - 2;  // take-over and release are not data

  logic clk, rst_n, clk_en, xfer_req, xfer_done, eng_access, as_n, bus_grant;
  logic bus_req, eng_run;

  int checks = 0;
  int bad = 0;
  bit summary_done = 0;
  logic [15:0] lfsr = 16'hACE1;

  bus_share_arbiter #(.ENG_WINDOW(ENG_W), .CPU_WINDOW(CPU_W)) u_bus_share_arbiter (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .eng_access(eng_access), .as_n(as_n),
    .bus_grant(bus_grant), .bus_req(bus_req), .eng_run(eng_run)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One enabled edge followed by one disabled edge; inputs hold throughout.
  task automatic tick();
    clk_en = 1'b1;
    @(posedge clk); #1;
    clk_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic next_gap(input int mode, output int g);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mode == 1) g = 10 + int'(lfsr % 16'd40);  // long, divide-like gaps
    else           g = 1 + int'(lfsr % 16'd4);
  endtask

  // Engine turn: grant the request, issue accesses with gaps, count them.
  task automatic engine_turn(input int stop_after, output int n);
    int g;
    int guard;
    n = 0;
    guard = 0;
    chk(bus_req === 1'b1, "R2 request pending before grant", int'(bus_req), 1);
    tick();
    chk(eng_run === 1'b0, "R2 no engine run without grant", int'(eng_run), 0);
    bus_grant = 1'b1;
    tick();
    chk(eng_run === 1'b1, "R2 engine runs after grant edge", int'(eng_run), 1);
    while (eng_run === 1'b1 && guard < 4000) begin
      guard++;
      if (stop_after >= 0 && n == stop_after) begin
        xfer_done = 1'b1;
        xfer_req  = 1'b0;
        tick();
        xfer_done = 1'b0;
        break;
      end
      next_gap(0, g);
      g = g - 1;  // 0..3 idle enabled edges
      repeat (g) tick();
      eng_access = 1'b1;
      tick();
      eng_access = 1'b0;
      n++;
    end
    chk(bus_req === 1'b0, "R3 request dropped with engine run", int'(bus_req), 0);
    bus_grant = 1'b0;
    tick();
  endtask

  // CPU turn: strobes with gaps until the request returns.
  // mode 0 short gaps, 1 long gaps, 2 stray engine pulses, 3 enable-low pulses.
  task automatic cpu_turn(input int mode, input int stop_after, output int n,
                          output bit early_req);
    int g;
    n = 0;
    early_req = 0;
    while (bus_req !== 1'b1 && n < 400) begin
      if (stop_after >= 0 && n == stop_after) begin
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        break;
      end
      as_n = 1'b0;
      tick();
      as_n = 1'b1;
      n++;
      if (bus_req === 1'b1) break;
      next_gap(mode, g);
      for (int k = 0; k < g; k++) begin
        if (mode == 2) eng_access = k[0];
        if (mode == 3) begin
          as_n = 1'b0; eng_access = 1'b1;
          @(posedge clk); #1;
          as_n = 1'b1; eng_access = 1'b0;
          @(posedge clk); #1;
        end
        tick();
        eng_access = 1'b0;
        if (bus_req === 1'b1) early_req = 1;
      end
    end
  endtask

  int n;
  bit early;

  initial begin
    rst_n = 1'b0; clk_en = 1'b0; xfer_req = 1'b0; xfer_done = 1'b0;
    eng_access = 1'b0; as_n = 1'b1; bus_grant = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(bus_req === 1'b0, "R1 bus_req in reset", int'(bus_req), 0);
    chk(eng_run === 1'b0, "R1 eng_run in reset", int'(eng_run), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      as_n = 1'b0; tick(); as_n = 1'b1; tick();
    end
    chk(bus_req === 1'b0, "R1 idle without xfer_req", int'(bus_req), 0);

    xfer_req = 1'b1;
    tick();
    chk(bus_req === 1'b1, "R2 request after xfer_req edge", int'(bus_req), 1);

    // Full turns under each gap pattern.
    for (int w = 0; w < 4; w++) begin
      engine_turn(-1, n);
      chk(n == DATA_EXP, $sformatf("R3 data accesses in engine turn %0d", w), n, DATA_EXP);
      cpu_turn(w, -1, n, early);
      chk(n == CPU_W && bus_req === 1'b1,
          $sformatf("R4 strobes in CPU turn mode %0d", w), n, CPU_W);
      chk(!early, $sformatf("R4 no request inside a gap mode %0d", w), int'(early), 0);
      if (w == 1) chk(n == CPU_W, "R4 long divide-like gaps still 64 strobes", n, CPU_W);
      if (w == 2) chk(n == CPU_W, "R9 stray engine pulses ignored", n, CPU_W);
      if (w == 3) chk(n == CPU_W, "R6 pulses with enable low not counted", n, CPU_W);
    end

    // Early finish inside the engine turn.
    engine_turn(10, n);
    chk(n == 10, "R7 engine stopped after finish", n, 10);
    chk(eng_run === 1'b0, "R7 engine run dropped", int'(eng_run), 0);
    for (int i = 0; i < 100; i++) begin
      as_n = 1'b0; tick(); as_n = 1'b1; tick();
    end
    chk(bus_req === 1'b0, "R7 idle after early finish", int'(bus_req), 0);
    xfer_req = 1'b1;
    tick();
    chk(bus_req === 1'b1, "R7 restart on new xfer_req", int'(bus_req), 1);
    engine_turn(-1, n);
    chk(n == DATA_EXP, "R5 counter cleared, full turn after restart", n, DATA_EXP);
    cpu_turn(0, -1, n, early);
    chk(n == CPU_W, "R5 CPU turn after restart", n, CPU_W);

    // Finish inside the CPU turn.
    engine_turn(-1, n);
    chk(n == DATA_EXP, "R3 turn before CPU-side finish", n, DATA_EXP);
    xfer_req = 1'b0;
    cpu_turn(0, 20, n, early);
    for (int i = 0; i < 80; i++) begin
      as_n = 1'b0; tick(); as_n = 1'b1; tick();
    end
    chk(bus_req === 1'b0, "R8 idle after finish in CPU turn", int'(bus_req), 0);

    // Finish while requesting.
    xfer_req = 1'b1;
    tick();
    chk(bus_req === 1'b1, "R8 request raised", int'(bus_req), 1);
    xfer_done = 1'b1; xfer_req = 1'b0;
    tick();
    xfer_done = 1'b0;
    chk(bus_req === 1'b0, "R8 request dropped on finish", int'(bus_req), 0);
    bus_grant = 1'b1;
    tick(); tick();
    chk(eng_run === 1'b0, "R8 late grant ignored when idle", int'(eng_run), 0);
    bus_grant = 1'b0;
    tick();

    summary();
  end
endmodule